// File: doc/BRIEF.md
# Single-Precision Fused Multiply-Add Special-Case Unit

This unit sits at the front of a binary32 fused multiply-add pipeline. It accepts one instruction word and three operand values per cycle. The word selects one of four variants: plain add, product minus addend, negated sum, or negated difference. The unit sorts each operand into zero, infinity, quiet NaN, signalling NaN or finite. One cycle later it either presents a finished special result or tells the arithmetic path to compute the answer. The operation is (A × C) ± B, with C as the multiplier and B as the addend. The assembly operand order is D, A, C, B.

Next to the result logic the unit keeps a sticky status register. This register splits the invalid-operation cases into separate flags: zero times infinity, infinity minus infinity, and signalling NaN input. It also holds overflow and inexact flags, which the arithmetic path reports through a separate input. When the record bit of the instruction is set, four summary bits are copied into a 4-bit condition field. The mantissa datapath, denormal handling and rounding are outside this block.

Top module: `fma_special_unit`

## Requirements
- R1: Bits 31:26 of the instruction word must equal 59. Bits 5:1 select the variant: 29 add, 28 subtract, 31 negated add, 30 negated subtract. Bit 0 is the record flag. Any other primary or extended value raises `illegal_op` for one cycle after the issue. In that case `res_valid` stays low, and neither `status` nor `cond_field` changes.
- R2: Every legal issue produces `res_valid` on the next cycle with exactly one of `res_special` and `res_datapath` high. Finite operands (including denormals) with no infinity or NaN select the datapath, and `res_value` then reads zero.
- R3: If any operand is a NaN, the result is the first NaN in the order A, B, C, with bit 22 forced to 1 and the sign kept. The negated variants do not flip it.
- R4: A signalling NaN operand (exponent all ones, bit 22 clear, fraction non-zero) sets status bit 2.
- R5: With no NaN operand, zero times infinity (in either order) returns 0x7FC00000 and sets status bit 0.
- R6: With no NaN operand, an infinite product meets an infinite addend whose effective sign differs. The effective sign is the sign of B, inverted for the subtract variants. The unit then returns 0x7FC00000 and sets status bit 1.
- R7: Otherwise, an infinite product gives infinity with the product's sign. An infinite addend with a finite product gives infinity with the effective addend sign. The negated variants then invert the sign.
- R8: Status bit 5 is the OR of bits 2, 1 and 0. Status bit 7 is set only when one of bits 4, 3, 2, 1 or 0 goes from 0 to 1.
- R9: Bits 7, 4, 3, 2, 1 and 0 stay set until a clear write. On that write, `clr_en` is high and each bit with a 1 in `clr_mask` is cleared. A set arriving in the same cycle wins. Mask bits 6 and 5 have no effect.
- R10: An `arith_ovf` pulse sets status bit 4 (overflow) and bit 3 (inexact).
- R11: A legal issue with the record flag loads `cond_field` = {bit 7, bit 6, bit 5, bit 4} of the updated status. Any other cycle leaves `cond_field` unchanged.
- R12: Status bit 6 equals (bit 5 AND `trap_en_invalid`) OR (bit 4 AND `trap_en_overflow`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction and operands are present |
| instr_word | input | 32 | Instruction word |
| opnd_a | input | 32 | Multiplicand A |
| opnd_c | input | 32 | Multiplier C |
| opnd_b | input | 32 | Addend B |
| arith_ovf | input | 1 | Arithmetic path reports a binary32 overflow |
| trap_en_invalid | input | 1 | Invalid-operation enable for the enabled-exception summary |
| trap_en_overflow | input | 1 | Overflow enable for the enabled-exception summary |
| clr_en | input | 1 | Status clear write |
| clr_mask | input | 8 | Bits of status to clear |
| res_valid | output | 1 | Result outputs are valid |
| res_special | output | 1 | `res_value` is the final result |
| res_datapath | output | 1 | Arithmetic path must compute the result |
| res_value | output | 32 | Special result value |
| illegal_op | output | 1 | Instruction word not recognised |
| status | output | 8 | {FX, FEX, VX, OX, XX, VXSNAN, VXISI, VXIMZ} |
| cond_field | output | 4 | Recorded {FX, FEX, VX, OX} |

## Verification
The bench targets the sign rules for infinities under each variant, including negative zero and negative infinity operands. A design that inverts the addend sign in the wrong variants would report an invalid operation on a legal infinite sum, or return the opposite infinity. It also checks NaN ordering when several operands are NaNs, and that a negated variant leaves a NaN's sign alone. Getting either wrong shows up as the wrong payload or sign.

The summary flag is checked by raising an invalid case a second time after the summary was cleared alone. A design that sets the summary on every exception, not only on new ones, fails that check. A record-form check follows a plain issue that carries an overflow. It catches a condition field that updates when it should hold.

// File: rtl/fma_sc_pkg.sv
package fma_sc_pkg;
  localparam int unsigned EXP_W = 8;
  localparam int unsigned MAN_W = 23;
  localparam int unsigned FW    = 1 + EXP_W + MAN_W;
  localparam int unsigned QBIT  = MAN_W - 1;

  localparam int unsigned SB_FX     = 7;
  localparam int unsigned SB_FEX    = 6;
  localparam int unsigned SB_VX     = 5;
  localparam int unsigned SB_OX     = 4;
  localparam int unsigned SB_XX     = 3;
  localparam int unsigned SB_VXSNAN = 2;
  localparam int unsigned SB_VXISI  = 1;
  localparam int unsigned SB_VXIMZ  = 0;
  localparam int unsigned STAT_W    = 8;

  localparam logic [FW-1:0] DEF_QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  typedef enum logic [1:0] {FOP_MADD, FOP_MSUB, FOP_NMADD, FOP_NMSUB} fop_e;
  typedef enum logic [2:0] {FC_ZERO, FC_INF, FC_QNAN, FC_SNAN, FC_FIN} fcls_e;

  function automatic fcls_e fp_class(input logic [FW-1:0] x);
    logic [EXP_W-1:0] e;
    logic [MAN_W-1:0] m;
    e = x[FW-2:MAN_W];
    m = x[MAN_W-1:0];
    if (e == {EXP_W{1'b1}}) begin
      if (m == '0)        return FC_INF;
      else if (m[QBIT])   return FC_QNAN;
      else                return FC_SNAN;
    end else if (e == '0 && m == '0) begin
      return FC_ZERO;
    end
    return FC_FIN;
  endfunction

  function automatic logic fp_is_nan(input fcls_e k);
    return (k == FC_QNAN) || (k == FC_SNAN);
  endfunction

  function automatic logic [FW-1:0] fp_quiet(input logic [FW-1:0] x);
    logic [FW-1:0] r;
    r = x;
    r[QBIT] = 1'b1;
    return r;
  endfunction

  function automatic logic [FW-1:0] fp_inf(input logic s);
    return {s, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
  endfunction
endpackage

// File: rtl/fma_sc_decode.sv
module fma_sc_decode
  import fma_sc_pkg::*;
#(
  parameter int unsigned PRI_OP = 59
) (
  input  logic [31:0] instr,
  output logic        legal,
  output fop_e        op,
  output logic        rec
);
  logic [5:0] pri_field;
  logic [4:0] xo_field;
  logic       xo_ok;
  logic       unused_fields;

  assign pri_field     = instr[31:26];
  assign xo_field      = instr[5:1];
  assign rec           = instr[0];
  assign unused_fields = ^instr[25:6];

  always_comb begin
    xo_ok = 1'b1;
    op    = FOP_MADD;
    unique case (xo_field)
      5'd28:   op = FOP_MSUB;
      5'd29:   op = FOP_MADD;
      5'd30:   op = FOP_NMSUB;
      5'd31:   op = FOP_NMADD;
      default: xo_ok = 1'b0;
    endcase
  end

  assign legal = xo_ok && (pri_field == PRI_OP[5:0]);
endmodule

// File: rtl/fma_sc_special.sv
module fma_sc_special
  import fma_sc_pkg::*;
(
  input  logic [FW-1:0] a,
  input  logic [FW-1:0] c,
  input  logic [FW-1:0] b,
  input  fop_e          op,
  output logic          special,
  output logic [FW-1:0] value,
  output logic          ev_snan,
  output logic          ev_imz,
  output logic          ev_isi
);
  fcls_e ka, kc, kb;
  logic  sa, sc, sb;
  logic  is_sub, is_neg;
  logic  any_nan;
  logic  prod_inf, add_inf_only;
  logic  psign, bsign_eff;
  logic  inf_out;
  logic  inf_sign;
  logic [FW-1:0] nan_pick;

  assign ka = fp_class(a);
  assign kc = fp_class(c);
  assign kb = fp_class(b);
  assign sa = a[FW-1];
  assign sc = c[FW-1];
  assign sb = b[FW-1];

  assign is_sub = (op == FOP_MSUB) || (op == FOP_NMSUB);
  assign is_neg = (op == FOP_NMADD) || (op == FOP_NMSUB);

  assign any_nan = fp_is_nan(ka) || fp_is_nan(kb) || fp_is_nan(kc);
  assign ev_snan = (ka == FC_SNAN) || (kb == FC_SNAN) || (kc == FC_SNAN);

  always_comb begin
    if (fp_is_nan(ka))      nan_pick = fp_quiet(a);
    else if (fp_is_nan(kb)) nan_pick = fp_quiet(b);
    else                    nan_pick = fp_quiet(c);
  end

  assign ev_imz = !any_nan &&
                  (((ka == FC_ZERO) && (kc == FC_INF)) ||
                   ((ka == FC_INF)  && (kc == FC_ZERO)));

  assign psign     = sa ^ sc;
  assign bsign_eff = sb ^ is_sub;
  assign prod_inf  = !any_nan && !ev_imz && ((ka == FC_INF) || (kc == FC_INF));
  assign ev_isi    = prod_inf && (kb == FC_INF) && (psign != bsign_eff);
  assign add_inf_only = !any_nan && !ev_imz && !prod_inf && (kb == FC_INF);

  assign inf_out  = (prod_inf && !ev_isi) || add_inf_only;
  assign inf_sign = (prod_inf ? psign : bsign_eff) ^ is_neg;

  assign special = any_nan || ev_imz || ev_isi || inf_out;

  always_comb begin
    if (any_nan)                 value = nan_pick;
    else if (ev_imz || ev_isi)   value = DEF_QNAN;
    else if (inf_out)            value = fp_inf(inf_sign);
    else                         value = '0;
  end

  always_comb begin
    assert_one_invalid_R6: assert (!(ev_imz && ev_isi));
  end
endmodule

// File: rtl/fma_sc_status.sv
module fma_sc_status
  import fma_sc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              rec_upd,
  input  logic              set_snan,
  input  logic              set_imz,
  input  logic              set_isi,
  input  logic              set_ovf,
  input  logic              en_inv,
  input  logic              en_ovf,
  input  logic              clr_en,
  input  logic [STAT_W-1:0] clr_mask,
  output logic [STAT_W-1:0] stat,
  output logic [3:0]        cond
);
  localparam int unsigned EXC_N = 5;

  logic             fx_q;
  logic [EXC_N-1:0] exc_q;
  logic [EXC_N-1:0] exc_mask, exc_kept, exc_set, exc_n;
  logic             fx_kept, fx_n, new_exc;
  logic             vx_n, fex_n, vx_cur, fex_cur;
  logic [3:0]       cond_q;

  assign exc_mask = clr_en ? {clr_mask[SB_OX], clr_mask[SB_XX], clr_mask[SB_VXSNAN],
                              clr_mask[SB_VXISI], clr_mask[SB_VXIMZ]} : '0;
  assign exc_kept = exc_q & ~exc_mask;
  assign fx_kept  = fx_q & !(clr_en && clr_mask[SB_FX]);
  assign exc_set  = {set_ovf, set_ovf, upd & set_snan, upd & set_isi, upd & set_imz};
  assign new_exc  = |(exc_set & ~exc_kept);
  assign exc_n    = exc_kept | exc_set;
  assign fx_n     = fx_kept | new_exc;
  assign vx_n     = |exc_n[2:0];
  assign fex_n    = (vx_n & en_inv) | (exc_n[4] & en_ovf);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fx_q   <= 1'b0;
      exc_q  <= '0;
      cond_q <= '0;
    end else begin
      fx_q  <= fx_n;
      exc_q <= exc_n;
      if (rec_upd) cond_q <= {fx_n, fex_n, vx_n, exc_n[4]};
    end
  end

  assign vx_cur  = |exc_q[2:0];
  assign fex_cur = (vx_cur & en_inv) | (exc_q[4] & en_ovf);
  assign stat    = {fx_q, fex_cur, vx_cur, exc_q};
  assign cond    = cond_q;

  assert_fx_on_new_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((exc_q & ~$past(exc_q)) != '0) |-> fx_q);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_en) |-> (({fx_q, exc_q} & $past({fx_q, exc_q})) == $past({fx_q, exc_q})));

  assert_cond_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rec_upd) |-> $stable(cond_q));
endmodule

// File: rtl/fma_special_unit.sv
module fma_special_unit
  import fma_sc_pkg::*;
#(
  parameter int unsigned PRI_OP = 59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [31:0]       instr_word,
  input  logic [FW-1:0]     opnd_a,
  input  logic [FW-1:0]     opnd_c,
  input  logic [FW-1:0]     opnd_b,
  input  logic              arith_ovf,
  input  logic              trap_en_invalid,
  input  logic              trap_en_overflow,
  input  logic              clr_en,
  input  logic [STAT_W-1:0] clr_mask,
  output logic              res_valid,
  output logic              res_special,
  output logic              res_datapath,
  output logic [FW-1:0]     res_value,
  output logic              illegal_op,
  output logic [STAT_W-1:0] status,
  output logic [3:0]        cond_field
);
  logic          dec_legal, dec_rec;
  fop_e          dec_op;
  logic          sp_hit, ev_snan, ev_imz, ev_isi;
  logic [FW-1:0] sp_value;
  logic          go, go_bad;

  logic          valid_q, spec_q, dp_q, illegal_q, imz_evt_q;
  logic [FW-1:0] value_q;

  fma_sc_decode #(.PRI_OP(PRI_OP)) u_decode (
    .instr (instr_word),
    .legal (dec_legal),
    .op    (dec_op),
    .rec   (dec_rec)
  );

  fma_sc_special u_special (
    .a       (opnd_a),
    .c       (opnd_c),
    .b       (opnd_b),
    .op      (dec_op),
    .special (sp_hit),
    .value   (sp_value),
    .ev_snan (ev_snan),
    .ev_imz  (ev_imz),
    .ev_isi  (ev_isi)
  );

  assign go     = issue_valid && dec_legal;
  assign go_bad = issue_valid && !dec_legal;

  fma_sc_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (go),
    .rec_upd  (go && dec_rec),
    .set_snan (ev_snan),
    .set_imz  (ev_imz),
    .set_isi  (ev_isi),
    .set_ovf  (arith_ovf),
    .en_inv   (trap_en_invalid),
    .en_ovf   (trap_en_overflow),
    .clr_en   (clr_en),
    .clr_mask (clr_mask),
    .stat     (status),
    .cond     (cond_field)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      spec_q    <= 1'b0;
      dp_q      <= 1'b0;
      illegal_q <= 1'b0;
      imz_evt_q <= 1'b0;
      value_q   <= '0;
    end else begin
      valid_q   <= go;
      spec_q    <= go && sp_hit;
      dp_q      <= go && !sp_hit;
      illegal_q <= go_bad;
      imz_evt_q <= go && ev_imz;
      value_q   <= go ? sp_value : '0;
    end
  end

  assign res_valid    = valid_q;
  assign res_special  = spec_q;
  assign res_datapath = dp_q;
  assign res_value    = value_q;
  assign illegal_op   = illegal_q;

  assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_special != res_datapath));

  assert_illegal_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> !res_valid);

  assert_imz_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && imz_evt_q) |-> (res_special && res_value == DEF_QNAN));

  assert_nan_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_special && res_value[FW-2:MAN_W] == {EXP_W{1'b1}} && res_value[MAN_W-1:0] != '0)
      |-> res_value[QBIT]);
endmodule

// File: tb/test_fma_special_unit.sv
module test_fma_special_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  localparam logic [31:0] I_MADD  = 32'hEC00003A;
  localparam logic [31:0] I_MSUB  = 32'hEC000038;
  localparam logic [31:0] I_NMSUB = 32'hEC00003C;
  localparam logic [31:0] I_NMADD = 32'hEC00003E;
  localparam logic [31:0] PINF = 32'h7F800000, NINF = 32'hFF800000;
  localparam logic [31:0] ONE  = 32'h3F800000, TWO  = 32'h40000000;
  localparam logic [31:0] DNAN = 32'h7FC00000;

  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] a;
    logic [31:0] c;
    logic [31:0] b;
    logic        spec;
    logic [31:0] res;
    logic [2:0]  flg;  // {snan, isi, imz}
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{I_MADD,  ONE,  TWO,  ONE,  1'b0, 32'h0,       3'b000},
    '{I_MADD,  32'h7FC00001, ONE, 32'h7F800005, 1'b1, 32'h7FC00001, 3'b100},
    '{I_MADD,  ONE, 32'h7F800005, 32'hFFC00010, 1'b1, 32'hFFC00010, 3'b100},
    '{I_MADD,  ONE, 32'h7F800005, ONE, 1'b1, 32'h7FC00005, 3'b100},
    '{I_NMADD, 32'hFFC00010, ONE, ONE, 1'b1, 32'hFFC00010, 3'b000},
    '{I_MADD,  32'h0, PINF, ONE,  1'b1, DNAN,        3'b001},
    '{I_MADD,  PINF, 32'h80000000, ONE, 1'b1, DNAN,  3'b001},
    '{I_MADD,  PINF, ONE,  NINF, 1'b1, DNAN,        3'b010},
    '{I_MSUB,  PINF, ONE,  PINF, 1'b1, DNAN,        3'b010},
    '{I_MADD,  PINF, ONE,  PINF, 1'b1, PINF,        3'b000},
    '{I_NMADD, PINF, ONE,  ONE,  1'b1, NINF,        3'b000},
    '{I_MSUB,  ONE,  ONE,  PINF, 1'b1, NINF,        3'b000},
    '{I_NMSUB, ONE,  ONE,  PINF, 1'b1, PINF,        3'b000},
    '{I_MADD,  NINF, TWO,  ONE,  1'b1, NINF,        3'b000},
    '{I_NMSUB, NINF, TWO,  NINF, 1'b1, DNAN,        3'b010},
    '{I_MSUB,  32'h0, ONE, 32'h0, 1'b0, 32'h0,      3'b000},
    '{I_MADD,  32'h00000001, ONE, ONE, 1'b0, 32'h0, 3'b000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [31:0] instr_word = '0, opnd_a = '0, opnd_c = '0, opnd_b = '0;
  logic        arith_ovf = 1'b0, trap_en_invalid = 1'b0, trap_en_overflow = 1'b0;
  logic        clr_en = 1'b0;
  logic [7:0]  clr_mask = '0;
  logic        res_valid, res_special, res_datapath, illegal_op;
  logic [31:0] res_value;
  logic [7:0]  status;
  logic [3:0]  cond_field;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fma_special_unit i_fma_special_unit (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr_word(instr_word),
    .opnd_a(opnd_a), .opnd_c(opnd_c), .opnd_b(opnd_b), .arith_ovf(arith_ovf),
    .trap_en_invalid(trap_en_invalid), .trap_en_overflow(trap_en_overflow),
    .clr_en(clr_en), .clr_mask(clr_mask), .res_valid(res_valid),
    .res_special(res_special), .res_datapath(res_datapath), .res_value(res_value),
    .illegal_op(illegal_op), .status(status), .cond_field(cond_field)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] c, input logic [31:0] b, input logic ovf);
    @(negedge clk);
    issue_valid = 1'b1; instr_word = ins; opnd_a = a; opnd_c = c; opnd_b = b; arith_ovf = ovf;
    @(negedge clk);
    issue_valid = 1'b0; arith_ovf = 1'b0;
  endtask

  task automatic clear(input logic [7:0] m);
    @(negedge clk);
    clr_en = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_en = 1'b0; clr_mask = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R2 reset valid", {31'b0, res_valid}, 32'd0);
    chk("R9 reset status", {24'b0, status}, 32'd0);
    chk("R11 reset cond", {28'b0, cond_field}, 32'd0);
    chk("R1 reset illegal", {31'b0, illegal_op}, 32'd0);

    // vector table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      clear(8'hFF);
      issue(VECS[i].ins, VECS[i].a, VECS[i].c, VECS[i].b, 1'b0);
      chk($sformatf("R2 vec%0d valid", i), {31'b0, res_valid}, 32'd1);
      chk($sformatf("R2 vec%0d special", i), {30'b0, res_special, res_datapath},
          {30'b0, VECS[i].spec, ~VECS[i].spec});
      chk($sformatf("R3/R5/R6/R7 vec%0d value", i), res_value, VECS[i].res);
      chk($sformatf("R4/R5/R6 vec%0d flags", i), {29'b0, status[2:0]}, {29'b0, VECS[i].flg});
      chk($sformatf("R8 vec%0d vx", i), {31'b0, status[5]}, {31'b0, |VECS[i].flg});
    end

    // R1 illegal primary opcode: would raise zero-times-infinity if accepted
    clear(8'hFF);
    issue(32'hFC00003A, 32'h0, PINF, ONE, 1'b0);
    chk("R1 bad primary illegal", {30'b0, illegal_op, res_valid}, 32'b10);
    chk("R1 bad primary status", {24'b0, status}, 32'd0);
    @(negedge clk);
    chk("R1 illegal one cycle", {31'b0, illegal_op}, 32'd0);
    issue(32'hEC000037, 32'h0, PINF, ONE, 1'b0);  // extended 27 with record bit
    chk("R1 bad xo illegal", {30'b0, illegal_op, res_valid}, 32'b10);
    chk("R1 bad xo cond", {28'b0, cond_field}, 32'd0);

    // R8 summary set only on new exception
    clear(8'hFF);
    issue(I_MADD, 32'h0, PINF, ONE, 1'b0);
    chk("R8 first imz", {24'b0, status}, 32'hA1);
    clear(8'h80);
    issue(I_MADD, 32'h0, PINF, ONE, 1'b0);
    chk("R8 repeat imz no FX", {24'b0, status}, 32'h21);
    issue(I_MADD, PINF, ONE, NINF, 1'b0);
    chk("R8 new isi sets FX", {24'b0, status}, 32'hA3);

    // R9 sticky and clear
    issue(I_MADD, ONE, ONE, ONE, 1'b0);
    chk("R9 sticky after finite", {24'b0, status}, 32'hA3);
    clear(8'h61);  // FEX/VX mask bits ignored
    chk("R9 partial clear", {24'b0, status}, 32'hA2);
    clear(8'hFF);
    chk("R9 full clear", {24'b0, status}, 32'd0);

    // R10 overflow
    @(negedge clk); arith_ovf = 1'b1;
    @(negedge clk); arith_ovf = 1'b0;
    chk("R10 overflow flags", {24'b0, status}, 32'h98);

    // R12 enabled summary
    trap_en_overflow = 1'b1;
    #1 chk("R12 fex from OX", {31'b0, status[6]}, 32'd1);
    trap_en_overflow = 1'b0;
    #1 chk("R12 fex off", {31'b0, status[6]}, 32'd0);

    // R11 record copy
    clear(8'hFF);
    issue(32'hEC00003B, 32'h0, PINF, ONE, 1'b0);
    chk("R11 record imz", {28'b0, cond_field}, 32'hA);
    issue(I_MADD, ONE, ONE, ONE, 1'b1);
    chk("R11 plain issue holds cond", {28'b0, cond_field}, 32'hA);
    chk("R10 ovf with issue", {31'b0, status[4]}, 32'd1);
    trap_en_invalid = 1'b1;
    issue(32'hEC00003F, ONE, ONE, ONE, 1'b0);
    chk("R11 R12 record with fex", {28'b0, cond_field}, 32'hF);
    trap_en_invalid = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule